// File: doc/BRIEF.md
# Round-Robin Interrupt Pending Selector

This block collects the interrupt lines of on-chip peripherals into a raw status vector of 32 or 64 bits. It combines that vector with an enable mask and, on each service request, grants one pending source. No source has fixed priority over another. A stored rotation pointer makes each search begin just past the previous winner, so every active source is eventually served.

A granted index can be reported as an internal source number or as an external line number. When cascading is switched on and the index lies inside a programmable inclusive window, the block flags the grant as external and numbers it relative to the window's lower bound.

A separate cause combiner sits alongside the selector. It takes eight processor-level cause lines and their enables. Line 2 is replaced by the selector's own "anything pending" summary. The combiner picks which line the processor should handle first.

Top module: `irq_rr_dispatch`

## Requirements
- R1: The pending vector is `irq_raw & mask_rd`. A grant only ever names an index whose pending bit was set in the cycle of the request.
- R2: On a request, the winner is the first pending index met when scanning upward from the rotation pointer and wrapping modulo W. The grant appears on `grant_valid`/`grant_num`/`grant_ext` in the cycle after the requesting edge.
- R3: After a grant of index k, the rotation pointer holds (k+1) mod W, so the next search begins just past k.
- R4: A request made while the pending vector is zero produces no grant and leaves the rotation pointer unchanged.
- R5: `mask_load` replaces the whole mask with `mask_word`. Otherwise `mask_set` sets bit `mask_sel` and `mask_clr` clears it, with clear winning when both are given. All other bits keep their value. `mask_rd` shows the mask.
- R6: With cascading on and lo <= k <= hi, a grant of index k has `grant_ext`=1 and `grant_num`=k-lo. Otherwise `grant_ext`=0 and `grant_num`=k. The window and enable are loaded by `casc_load` and apply to requests from the following cycle.
- R7: After reset, the pointer is 0, the mask is all zeros, cascading is off, and `grant_valid`, `grant_ext` and `grant_num` are 0.
- R8: The effective causes are `cpu_pend & cpu_en`, with bit 2 replaced by (pending vector non-zero). `cpu_pend[2]` is ignored. `cause_line` picks 7 first, then 2, then 3, 4, 5, 6 in that order. Lines 0 and 1 are never picked. `cause_valid` is 1 when a line is picked, and `cause_line` is 0 otherwise.
- R9: While cascading is on, lines 3 to 6 are never picked.
- R10: `grant_valid` is a one-cycle pulse per requesting edge. It is never 1 in a cycle that did not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | W | Raw peripheral interrupt status |
| mask_load | input | 1 | Load the whole mask from `mask_word` |
| mask_word | input | W | Full mask value |
| mask_set | input | 1 | Set mask bit `mask_sel` |
| mask_clr | input | 1 | Clear mask bit `mask_sel` |
| mask_sel | input | log2(W) | Bit index for set/clear |
| mask_rd | output | W | Current mask |
| casc_load | input | 1 | Load the cascade configuration |
| casc_on_in | input | 1 | Cascade enable value |
| casc_lo_in | input | log2(W) | Window lower bound |
| casc_hi_in | input | log2(W) | Window upper bound |
| pick_req | input | 1 | Service request |
| grant_valid | output | 1 | Grant pulse |
| grant_ext | output | 1 | Grant is an external line |
| grant_num | output | log2(W) | Granted internal index or external number |
| cpu_pend | input | 8 | Processor cause lines |
| cpu_en | input | 8 | Processor cause enables |
| cause_valid | output | 1 | A cause line is selected |
| cause_line | output | 3 | Selected cause line |

## Verification
The assertions check the following on every cycle:
- every winner was pending;
- the pointer always sits one past the last grant;
- an empty request leaves the pointer still;
- grants occur only after requests;
- per-bit mask strobes reach their bit;
- cascading-off grants are internal;
- the combiner picks line 7 first and never picks lines 3 to 6 while cascading.

Only the bench's scenarios can show the fairness of the rotation over sequences of requests, the exact window arithmetic, and that untouched mask bits survive strobes. They compare a behavioural model on every clock, with both directed patterns and a long randomised phase.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

  localparam int unsigned MAX_W = 64;

  // Circular first-set search: returns {found, index}
  function automatic logic [6:0] rr_scan(input logic [MAX_W-1:0] pend,
                                         input int unsigned w,
                                         input int unsigned ptr);
    logic found;
    logic [5:0] idx;
    int unsigned j;
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < int'(w) && !found) begin
        j = (ptr + i) % w;
        if (pend[j]) begin
          found = 1'b1;
          idx   = 6'(j);
        end
      end
    end
    return {found, idx};
  endfunction

  // Cascade window remap: returns {ext, number}
  function automatic logic [6:0] casc_map(input logic on,
                                          input logic [5:0] idx,
                                          input logic [5:0] lo,
                                          input logic [5:0] hi);
    logic inwin;
    inwin = on && (idx >= lo) && (idx <= hi);
    return inwin ? {1'b1, 6'(idx - lo)} : {1'b0, idx};
  endfunction

  // Cause ordering: 7, then 2, then 3..6 unless cascading. Returns {valid, line}
  function automatic logic [3:0] cause_pick(input logic [7:0] eff,
                                            input logic casc);
    logic [3:0] r;
    r = 4'd0;
    if (eff[7])                r = {1'b1, 3'd7};
    else if (eff[2])           r = {1'b1, 3'd2};
    else if (!casc && eff[3])  r = {1'b1, 3'd3};
    else if (!casc && eff[4])  r = {1'b1, 3'd4};
    else if (!casc && eff[5])  r = {1'b1, 3'd5};
    else if (!casc && eff[6])  r = {1'b1, 3'd6};
    return r;
  endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    word,
  input  logic            set,
  input  logic            clr,
  input  logic [IDXW-1:0] sel,
  output logic [W-1:0]    mask
);

  logic [W-1:0] mask_next;

  always_comb begin
    mask_next = mask;
    if (load) begin
      mask_next = word;
    end else begin
      if (set) mask_next[sel] = 1'b1;
      if (clr) mask_next[sel] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_next;
  end

  AST_CLR_DROPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> !mask[$past(sel)]); // R5
  AST_SET_RAISES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr && !load) |=> mask[$past(sel)]); // R5

endmodule

// File: rtl/irq_rr_picker.sv
module irq_rr_picker
  import irq_rr_pkg::*;
#(
  parameter int W = 32,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [W-1:0]    pend,
  output logic            hit,
  output logic [IDXW-1:0] win,
  output logic            vld_q,
  output logic [IDXW-1:0] ptr
);

  logic [6:0]      scan;
  logic [IDXW-1:0] idx_q;
  logic            adv;

  assign scan = rr_scan(MAX_W'(pend), W, int'(ptr));
  assign hit  = scan[6];
  assign win  = scan[IDXW-1:0];
  assign adv  = req && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= adv;
      if (adv) begin
        idx_q <= win;
        ptr   <= win + 1'b1;
      end
    end
  end

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pend[win]); // R1
  AST_PTR_PAST_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (ptr == IDXW'(idx_q + 1'b1))); // R3
  AST_IDLE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (pend == '0)) |=> (!vld_q && $stable(ptr))); // R4
  AST_REQ_BEFORE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(req)); // R10

endmodule

// File: rtl/irq_casc_map.sv
module irq_casc_map
  import irq_rr_pkg::*;
#(
  parameter int W = 32,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            cfg_on,
  input  logic [IDXW-1:0] cfg_lo,
  input  logic [IDXW-1:0] cfg_hi,
  input  logic            adv,
  input  logic [IDXW-1:0] win,
  output logic            casc_on,
  output logic            ext_q,
  output logic [IDXW-1:0] num_q
);

  logic [IDXW-1:0] lo_q, hi_q;
  logic [6:0]      mapped;

  assign mapped = casc_map(casc_on, 6'(win), 6'(lo_q), 6'(hi_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_on <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (cfg_load) begin
      casc_on <= cfg_on;
      lo_q    <= cfg_lo;
      hi_q    <= cfg_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      num_q <= '0;
    end else if (adv) begin
      ext_q <= mapped[6];
      num_q <= mapped[IDXW-1:0];
    end else begin
      ext_q <= 1'b0;
      num_q <= '0;
    end
  end

  AST_EXT_NEEDS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !casc_on) |=> !ext_q); // R6

endmodule

// File: rtl/irq_cause_mux.sv
module irq_cause_mux
  import irq_rr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cpu_pend,
  input  logic [7:0] cpu_en,
  input  logic       int_any,
  input  logic       casc_on,
  output logic       cause_valid,
  output logic [2:0] cause_line
);

  logic [7:0] eff;
  logic [3:0] pick;

  assign eff  = {cpu_pend[7:3], int_any, cpu_pend[1:0]} & cpu_en;
  assign pick = cause_pick(eff, casc_on);
  assign cause_valid = pick[3];
  assign cause_line  = pick[2:0];

  AST_CAUSE_TOP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    eff[7] |-> (cause_valid && cause_line == 3'd7)); // R8
  AST_CAUSE_CASC_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && casc_on) |-> (cause_line == 3'd7 || cause_line == 3'd2)); // R9

endmodule

// File: rtl/irq_rr_dispatch.sv
module irq_rr_dispatch #(
  parameter int W = 32,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    irq_raw,
  input  logic            mask_load,
  input  logic [W-1:0]    mask_word,
  input  logic            mask_set,
  input  logic            mask_clr,
  input  logic [IDXW-1:0] mask_sel,
  output logic [W-1:0]    mask_rd,
  input  logic            casc_load,
  input  logic            casc_on_in,
  input  logic [IDXW-1:0] casc_lo_in,
  input  logic [IDXW-1:0] casc_hi_in,
  input  logic            pick_req,
  output logic            grant_valid,
  output logic            grant_ext,
  output logic [IDXW-1:0] grant_num,
  input  logic [7:0]      cpu_pend,
  input  logic [7:0]      cpu_en,
  output logic            cause_valid,
  output logic [2:0]      cause_line
);

  logic [W-1:0]    pend;
  logic            hit;
  logic [IDXW-1:0] win;
  logic [IDXW-1:0] ptr;
  logic            casc_on;

  assign pend = irq_raw & mask_rd;

  irq_mask_reg #(.W(W), .IDXW(IDXW)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_load), .word(mask_word),
    .set(mask_set), .clr(mask_clr), .sel(mask_sel), .mask(mask_rd)
  );

  irq_rr_picker #(.W(W), .IDXW(IDXW)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(pick_req), .pend(pend),
    .hit(hit), .win(win), .vld_q(grant_valid), .ptr(ptr)
  );

  irq_casc_map #(.W(W), .IDXW(IDXW)) u_map (
    .clk(clk), .rst_n(rst_n), .cfg_load(casc_load), .cfg_on(casc_on_in),
    .cfg_lo(casc_lo_in), .cfg_hi(casc_hi_in), .adv(pick_req && hit),
    .win(win), .casc_on(casc_on), .ext_q(grant_ext), .num_q(grant_num)
  );

  irq_cause_mux u_cause (
    .clk(clk), .rst_n(rst_n), .cpu_pend(cpu_pend), .cpu_en(cpu_en),
    .int_any(|pend), .casc_on(casc_on),
    .cause_valid(cause_valid), .cause_line(cause_line)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |->
    (!grant_valid && ptr == '0 && mask_rd == '0)); // R7

endmodule

// File: tb/irq_rr_dispatch_tb_top.sv
module irq_rr_dispatch_tb_top;
  localparam int W = 32;
  localparam int IDXW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] irq_raw = '0, mask_word = '0;
  logic mask_load = 0, mask_set = 0, mask_clr = 0;
  logic [IDXW-1:0] mask_sel = '0, casc_lo_in = '0, casc_hi_in = '0;
  logic casc_load = 0, casc_on_in = 0, pick_req = 0;
  logic [7:0] cpu_pend = '0, cpu_en = '0;
  logic [W-1:0] mask_rd;
  logic grant_valid, grant_ext, cause_valid;
  logic [IDXW-1:0] grant_num;
  logic [2:0] cause_line;

  always #5 clk = ~clk; // 100 MHz

  irq_rr_dispatch #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .mask_load(mask_load),
    .mask_word(mask_word), .mask_set(mask_set), .mask_clr(mask_clr),
    .mask_sel(mask_sel), .mask_rd(mask_rd), .casc_load(casc_load),
    .casc_on_in(casc_on_in), .casc_lo_in(casc_lo_in), .casc_hi_in(casc_hi_in),
    .pick_req(pick_req), .grant_valid(grant_valid), .grant_ext(grant_ext),
    .grant_num(grant_num), .cpu_pend(cpu_pend), .cpu_en(cpu_en),
    .cause_valid(cause_valid), .cause_line(cause_line)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit [W-1:0] m_mask;
  int m_ptr, m_lo, m_hi;
  bit m_on, e_vld, e_ext;
  int e_num;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit [W-1:0] p;
    int w;
    if (!rst_n) begin
      m_mask = '0; m_ptr = 0; m_on = 0; m_lo = 0; m_hi = 0;
      e_vld = 0; e_ext = 0; e_num = 0;
      return;
    end
    p = irq_raw & m_mask;
    e_vld = 0; e_ext = 0; e_num = 0;
    if (pick_req && p != 0) begin
      w = -1;
      for (int i = 0; i < W; i++)
        if (w < 0 && p[(m_ptr + i) % W]) w = (m_ptr + i) % W;
      e_vld = 1;
      if (m_on && w >= m_lo && w <= m_hi) begin e_ext = 1; e_num = w - m_lo; end
      else e_num = w;
      m_ptr = (w + 1) % W;
    end
    if (mask_load) m_mask = mask_word;
    else begin
      if (mask_set) m_mask[mask_sel] = 1'b1;
      if (mask_clr) m_mask[mask_sel] = 1'b0;
    end
    if (casc_load) begin m_on = casc_on_in; m_lo = casc_lo_in; m_hi = casc_hi_in; end
  endtask

  task automatic compare();
    bit [7:0] eff;
    int line; bit v;
    eff = cpu_pend & cpu_en;
    eff[2] = ((irq_raw & m_mask) != 0) && cpu_en[2];
    v = 1; line = 0;
    if (eff[7]) line = 7;
    else if (eff[2]) line = 2;
    else if (!m_on && eff[3]) line = 3;
    else if (!m_on && eff[4]) line = 4;
    else if (!m_on && eff[5]) line = 5;
    else if (!m_on && eff[6]) line = 6;
    else v = 0;
    chk("R10 grant_valid", grant_valid, e_vld);
    chk("R2 grant_num", grant_num, e_num);
    chk("R6 grant_ext", grant_ext, e_ext);
    chk("R5 mask_rd", mask_rd, m_mask);
    chk("R8 cause_valid", cause_valid, v);
    chk("R8 cause_line", cause_line, line);
  endtask

  task automatic cyc();
    @(posedge clk); model_edge();
    @(negedge clk); compare();
    mask_load = 0; mask_set = 0; mask_clr = 0; casc_load = 0; pick_req = 0;
  endtask

  task automatic req_once();
    pick_req = 1; cyc();
  endtask

  initial begin
    rst_n = 0;
    cyc(); cyc();
    // R7: reset state
    chk("R7 mask", mask_rd, 0);
    chk("R7 valid", grant_valid, 0);
    rst_n = 1;
    irq_raw = 32'h0010_0408; // bits 3,10,20
    req_once(); chk("R1 no grant with mask zero", grant_valid, 0);
    mask_word = '1; mask_load = 1; cyc();
    // R2/R3 rotation 3,10,20,3
    req_once(); chk("R2 first", grant_num, 3);
    req_once(); chk("R3 next", grant_num, 10);
    req_once(); chk("R3 next", grant_num, 20);
    req_once(); chk("R3 wrap", grant_num, 3);
    // R4: empty request keeps pointer at 4
    irq_raw = '0; req_once(); chk("R4 no grant", grant_valid, 0);
    irq_raw = 32'h0000_0204; // bits 2,9
    req_once(); chk("R4 pointer kept", grant_num, 9);
    // R5: clear bit 9, other bits untouched
    mask_sel = 5'd9; mask_clr = 1; cyc();
    chk("R5 clear one bit", mask_rd, 32'hFFFF_FDFF);
    req_once(); chk("R1 masked skipped", grant_num, 2);
    mask_set = 1; mask_clr = 1; cyc();
    chk("R5 clear wins", mask_rd[9], 0);
    mask_set = 1; cyc(); chk("R5 set", mask_rd, 32'hFFFF_FFFF);
    // R6: cascade window 8..11
    casc_load = 1; casc_on_in = 1; casc_lo_in = 5'd8; casc_hi_in = 5'd11; cyc();
    irq_raw = 32'h0000_1200; // bits 9,12
    req_once(); chk("R6 ext flag", grant_ext, 1); chk("R6 ext num", grant_num, 1);
    req_once(); chk("R6 outside window", grant_ext, 0); chk("R6 raw num", grant_num, 12);
    // R10: held request gives one pulse per edge, then stops
    irq_raw = 32'h8000_0001;
    pick_req = 1; cyc(); pick_req = 1; cyc();
    chk("R10 pulse", grant_valid, 1);
    cyc(); chk("R10 no request", grant_valid, 0);
    // R8/R9 cause ordering
    cpu_en = 8'hFF; irq_raw = '0;
    cpu_pend = 8'h7C; cyc(); chk("R9 cascaded skips 3..6", cause_valid, 0);
    cpu_pend = 8'hFF; cyc(); chk("R8 line7 first", cause_line, 7);
    irq_raw = 32'h1; cpu_pend = 8'h7B; cyc(); chk("R8 summary line2", cause_line, 2);
    casc_load = 1; casc_on_in = 0; cyc();
    irq_raw = '0; cpu_pend = 8'h34; cyc(); chk("R8 line4 pend2 ignored", cause_line, 4);
    // randomised phase
    for (int k = 0; k < 4000; k++) begin
      irq_raw = $urandom & $urandom;
      pick_req = $urandom_range(0, 3) != 0;
      mask_sel = IDXW'($urandom);
      mask_set = $urandom_range(0, 5) == 0;
      mask_clr = $urandom_range(0, 5) == 0;
      mask_load = $urandom_range(0, 40) == 0;
      mask_word = $urandom;
      casc_load = $urandom_range(0, 50) == 0;
      casc_on_in = $urandom_range(0, 1) == 1;
      casc_lo_in = IDXW'($urandom_range(0, 15));
      casc_hi_in = IDXW'($urandom_range(16, 31));
      cpu_pend = 8'($urandom); cpu_en = 8'($urandom);
      cyc();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule